// File: doc/BRIEF.md
# Pin I/O Controller with Edge-Event Interrupts

This block is a 32-pin general-purpose I/O controller on a small register bus. Software picks each pin's direction, writes output values into a latch, reads back pin levels, and collects pin transitions as sticky event flags that combine, through a per-pin enable mask, into one interrupt line. Pin inputs pass through a two-flop synchronizer before any use, and a transition is found by comparing the newest synchronized sample with the one before it.

Which transitions raise an event is set per pin. With `WIDE_SENSE = 0` every pin has one sense bit (falling only, or both directions). With `WIDE_SENSE = 1` every pin has a two-bit field: the first sense register holds the fields for pins 0–15 and the second holds those for pins 16–31. In that mode the four highest-numbered pins can only be inputs. Every register is 32 bits wide, and pin n always sits at bit 31−n.

Register byte offsets: 0x00 direction, 0x04 reserved, 0x08 data, 0x0C events, 0x10 mask, 0x14 first sense register, 0x18 second sense register. A write happens on a clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr`.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are all 0, and `irq` is low.
- R2: Pin n corresponds to bit 31−n of every register, and pin n is bit n of `pin_in`, `pin_out` and `pin_oe`.
- R3: A direction bit of 1 sets `pin_oe[n]` and makes the pin an output that drives the data-latch bit on `pin_out[n]`. A 0 makes the pin an input.
- R4: A data-register read returns the latch bit for output pins and the synchronized level for input pins. A level change on `pin_in` appears in the read after two rising clock edges.
- R5: The event register clears on a write of 1 to a bit. Writing a single 1 clears only that pin's event, and writing all ones clears every event.
- R6: `irq` is high exactly when the bitwise AND of the event and mask registers is nonzero. A mask bit of 1 enables its pin.
- R7: A pin whose direction bit is 1 never sets its event bit.
- R8: With `WIDE_SENSE = 0`, sense bit 1 latches only falling transitions and sense bit 0 latches both directions. The second sense register reads 0 and is not used.
- R9: With `WIDE_SENSE = 1`, pin p uses the two bits at shift (15 − (p mod 16))·2. For p < 16 these are in the first sense register (0x14), and for p ≥ 16 in the second (0x18). The code 2'b10 selects falling, 2'b01 rising, 2'b00 both directions, and 2'b11 none.
- R10: With `WIDE_SENSE = 1`, pins 28–31 (direction bits 3..0) stay inputs. Those direction bits read back 0 whatever is written.
- R11: When a pin's event is being set in the same cycle that a 1 is written to clear it, the event stays set.
- R12: Offset 0x04 always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears every register |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Pin levels; bit n is pin n; asynchronous |
| pin_out | output | 32 | Output values; bit n is pin n |
| pin_oe | output | 32 | Output enables; bit n is pin n |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_in` is low on every pin while reset is held, so the synchronizer does not report a rise just after reset. The bench keeps every pin low through reset. The assertions also assume that bus signals change only away from the rising edge, and the bench drives the bus and pins only at falling edges. The same bus and pins drive one instance of each sense mode, and the expected value for each instance is computed separately. A pin transition is placed on purpose in the cycle of an event-clearing write, to reach the set-versus-clear collision that the assertions watch.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_DIR   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_RSV   = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_DAT   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_EVT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_MSK   = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_SNS_A = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_SNS_B = 5'h18;

    typedef enum logic [1:0] {
        SNS_BOTH = 2'b00,
        SNS_RISE = 2'b01,
        SNS_FALL = 2'b10,
        SNS_OFF  = 2'b11
    } sense_t;
endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pin_in;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl  = sy_q.s2;
    assign rise = sy_q.s2 & ~sy_q.prev;
    assign fall = ~sy_q.s2 & sy_q.prev;

    // R4: the synchronized level follows the first stage one cycle later
    a_r4_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl == $past(sy_q.s1)));
endmodule

// File: rtl/pio_edge_sel.sv
module pio_edge_sel
    import pio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter bit WIDE_SENSE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] sns_a,
    input  logic [NPINS-1:0] sns_b,
    output logic [NPINS-1:0] hit
);
    localparam int HALF = NPINS / 2;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (WIDE_SENSE) begin : g_wide
            logic [1:0] fld;
            if (p < HALF) begin : g_lo
                assign fld = sns_a[(HALF-1-p)*2 +: 2];
            end else begin : g_hi
                assign fld = sns_b[(HALF-1-(p-HALF))*2 +: 2];
            end
            always_comb begin
                case (fld)
                    SNS_FALL: hit[p] = fall[p];
                    SNS_RISE: hit[p] = rise[p];
                    SNS_BOTH: hit[p] = rise[p] | fall[p];
                    default:  hit[p] = 1'b0;
                endcase
            end
        end else begin : g_narrow
            assign hit[p] = sns_a[NPINS-1-p] ? fall[p] : (rise[p] | fall[p]);
        end
    end

    // R8 R9: a qualified hit always comes from a real transition
    a_r9_hit_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~(rise | fall)) == '0);
endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
    import pio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter bit WIDE_SENSE = 1'b1,
    parameter int RO_PINS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam logic [NPINS-1:0] ALL_ONES  = '1;
    localparam logic [NPINS-1:0] DIR_WMASK = WIDE_SENSE ? (ALL_ONES << RO_PINS) : ALL_ONES;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dat;
        logic [NPINS-1:0] evt;
        logic [NPINS-1:0] msk;
        logic [NPINS-1:0] sns_a;
        logic [NPINS-1:0] sns_b;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPINS-1:0] lvl_p, rise_p, fall_p, hit_p;
    logic [NPINS-1:0] lvl_r, hit_r, evt_set, evt_clr;
    logic             wr;

    pio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl_p),
        .rise   (rise_p),
        .fall   (fall_p)
    );

    pio_edge_sel #(.NPINS(NPINS), .WIDE_SENSE(WIDE_SENSE)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise_p),
        .fall  (fall_p),
        .sns_a (r_q.sns_a),
        .sns_b (r_q.sns_b),
        .hit   (hit_p)
    );

    // pin n <-> register bit NPINS-1-n
    for (genvar n = 0; n < NPINS; n++) begin : g_map
        assign lvl_r[NPINS-1-n] = lvl_p[n];
        assign hit_r[NPINS-1-n] = hit_p[n];
        assign pin_out[n]       = r_q.dat[NPINS-1-n];
        assign pin_oe[n]        = r_q.dir[NPINS-1-n];
    end

    assign wr      = bus_en & bus_we;
    assign evt_set = hit_r & ~r_q.dir;
    assign evt_clr = (wr && bus_addr == OFF_EVT) ? bus_wdata : '0;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (bus_addr)
                OFF_DIR:   r_d.dir   = bus_wdata & DIR_WMASK;
                OFF_DAT:   r_d.dat   = bus_wdata;
                OFF_MSK:   r_d.msk   = bus_wdata;
                OFF_SNS_A: r_d.sns_a = bus_wdata;
                OFF_SNS_B: if (WIDE_SENSE) r_d.sns_b = bus_wdata;
                default:   ;
            endcase
        end
        // set wins over clear
        r_d.evt = (r_q.evt & ~evt_clr) | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            OFF_DIR:   bus_rdata = r_q.dir;
            OFF_DAT:   bus_rdata = (r_q.dat & r_q.dir) | (lvl_r & ~r_q.dir);
            OFF_EVT:   bus_rdata = r_q.evt;
            OFF_MSK:   bus_rdata = r_q.msk;
            OFF_SNS_A: bus_rdata = r_q.sns_a;
            OFF_SNS_B: bus_rdata = WIDE_SENSE ? r_q.sns_b : '0;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(r_q.evt & r_q.msk);

    // R5: bits written as 1 are cleared unless a new event lands on them
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_EVT) |=> ((r_q.evt & $past(bus_wdata) & ~$past(evt_set)) == '0));

    // R11: a qualified transition is never lost
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((r_q.evt & $past(evt_set)) == $past(evt_set)));

    // R7: output pins gain no new events
    a_r7_out_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.evt & ~$past(r_q.evt) & $past(r_q.dir)) == '0));

    // R6: interrupt needs both a pending event and an enabled mask bit
    a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.msk == '0) || (r_q.evt == '0)) |-> !irq);

    if (WIDE_SENSE) begin : g_ro_chk
        // R10: the top pins are never driven
        a_r10_ro_pins: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[NPINS-1 -: RO_PINS] == '0);
    end
endmodule

// File: tb/pio_edge_ctrl_test.sv
`timescale 1ns/1ps
module pio_edge_ctrl_test;
    import pio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd_w, rd_n, out_w, out_n, oe_w, oe_n;
    logic        irq_w, irq_n;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    pio_edge_ctrl #(.WIDE_SENSE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w),
        .pin_in(pin_in), .pin_out(out_w), .pin_oe(oe_w), .irq(irq_w));

    pio_edge_ctrl #(.WIDE_SENSE(1'b0)) uut_n (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_n),
        .pin_in(pin_in), .pin_out(out_n), .pin_oe(oe_n), .irq(irq_n));

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] w;
        logic [31:0] exp_w;
        logic [31:0] exp_n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{OFF_DIR,   32'h0000_00FF, 32'h0000_00F0, 32'h0000_00FF}, // R10
        '{OFF_DIR,   32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFF}, // R10
        '{OFF_DIR,   32'h0000_0000, 32'h0000_0000, 32'h0000_0000}, // R3
        '{OFF_RSV,   32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}, // R12
        '{OFF_MSK,   32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5}, // R6
        '{OFF_MSK,   32'h0000_0000, 32'h0000_0000, 32'h0000_0000}, // R6
        '{OFF_SNS_A, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678}, // R9
        '{OFF_SNS_B, 32'h9ABC_DEF0, 32'h9ABC_DEF0, 32'h0000_0000}, // R8
        '{OFF_SNS_A, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}, // R9
        '{OFF_SNS_B, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}  // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] vw, output logic [31:0] vn);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        vw = rd_w; vn = rd_n;
        bus_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // drive pin p to level v, wait, read events of both instances, clear them
    task automatic pin_evt(input int p, input logic v, input string tag,
                           input logic [31:0] ew, input logic [31:0] en);
        logic [31:0] vw, vn;
        @(negedge clk);
        pin_in[p] = v;
        settle();
        rd(OFF_EVT, vw, vn);
        chk({tag, " wide"}, vw, ew);
        chk({tag, " narrow"}, vn, en);
        wr(OFF_EVT, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] vw, vn;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), vw, vn);
            chk("R1 reg wide", vw, 32'h0);
            chk("R1 reg narrow", vn, 32'h0);
        end
        chk("R1 oe", oe_w | oe_n | out_w | out_n, 32'h0);
        chk("R1 irq", {31'h0, irq_w | irq_n}, 32'h0);
        rst_n = 1'b1;
        settle();

        // register walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].w);
            rd(VEC[i].a, vw, vn);
            chk($sformatf("vector %0d wide", i), vw, VEC[i].exp_w);
            chk($sformatf("vector %0d narrow", i), vn, VEC[i].exp_n);
        end

        // R10 top pins never driven in wide mode
        wr(OFF_DIR, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 oe wide", oe_w, 32'h0FFF_FFFF);
        chk("R10 oe narrow", oe_n, 32'hFFFF_FFFF);
        wr(OFF_DIR, 32'h0);

        // R2 R3 pin 3 as output: data first, then direction (bit 28)
        wr(OFF_DAT, 32'h1000_0000);
        wr(OFF_DIR, 32'h1000_0000);
        @(negedge clk);
        chk("R2 R3 pin_out", out_w, 32'h0000_0008);
        chk("R2 R3 pin_oe", oe_n, 32'h0000_0008);

        // R4 input pin 0 high -> data bit 31, plus output latch of pin 3
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        bus_addr = OFF_DAT;
        #1;
        chk("R4 two-edge lag", rd_w, 32'h9000_0000);
        // R8 R9 both-edges default latched the rise of pin 0
        rd(OFF_EVT, vw, vn);
        chk("R9 both rise wide", vw, 32'h8000_0000);
        chk("R8 both rise narrow", vn, 32'h8000_0000);

        // R6 interrupt with mask
        chk("R6 masked off", {31'h0, irq_w}, 32'h0);
        wr(OFF_MSK, 32'h8000_0000);
        @(negedge clk);
        chk("R6 irq on", {31'h0, irq_w & irq_n}, 32'h1);
        // R5 clear the wrong bit, then the right one
        wr(OFF_EVT, 32'h4000_0000);
        rd(OFF_EVT, vw, vn);
        chk("R5 other bit kept", vw, 32'h8000_0000);
        wr(OFF_EVT, 32'h8000_0000);
        rd(OFF_EVT, vw, vn);
        chk("R5 bit cleared", vw | vn, 32'h0);
        chk("R6 irq off", {31'h0, irq_w | irq_n}, 32'h0);
        wr(OFF_MSK, 32'h0);
        pin_in[0] = 1'b0;
        settle();
        wr(OFF_EVT, 32'hFFFF_FFFF);

        // R7 pin 3 is output: toggling its input sets nothing
        pin_evt(3, 1'b1, "R7 out rise", 32'h0, 32'h0);
        pin_evt(3, 1'b0, "R7 out fall", 32'h0, 32'h0);
        wr(OFF_DIR, 32'h0);

        // R9 pin 5 field at shift 20 = falling; narrow pin 5 bit 26 = 0 -> both
        wr(OFF_SNS_A, 32'h0020_0000);
        pin_evt(5, 1'b1, "R9 fall-only rise", 32'h0, 32'h0400_0000);
        pin_evt(5, 1'b0, "R9 fall-only fall", 32'h0400_0000, 32'h0400_0000);
        // R9 rising code
        wr(OFF_SNS_A, 32'h0010_0000);
        pin_evt(5, 1'b1, "R9 rise-only rise", 32'h0400_0000, 32'h0400_0000);
        pin_evt(5, 1'b0, "R9 rise-only fall", 32'h0, 32'h0400_0000);
        // R9 code 11 -> nothing
        wr(OFF_SNS_A, 32'h0030_0000);
        pin_evt(5, 1'b1, "R9 off rise", 32'h0, 32'h0400_0000);
        pin_evt(5, 1'b0, "R9 off fall", 32'h0, 32'h0400_0000);
        // R9 pin 20 uses second register, shift 22, falling
        wr(OFF_SNS_A, 32'h0);
        wr(OFF_SNS_B, 32'h0080_0000);
        pin_evt(20, 1'b1, "R9 upper rise", 32'h0, 32'h0000_0800);
        pin_evt(20, 1'b0, "R9 upper fall", 32'h0000_0800, 32'h0000_0800);
        wr(OFF_SNS_B, 32'h0);
        // R8 narrow bit 26 = pin 5 falling only; wide pin 5 field = 00 both
        wr(OFF_SNS_A, 32'h0400_0000);
        pin_evt(5, 1'b1, "R8 narrow rise", 32'h0400_0000, 32'h0);
        pin_evt(5, 1'b0, "R8 narrow fall", 32'h0400_0000, 32'h0400_0000);
        wr(OFF_SNS_A, 32'h0);

        // R11 clear-all write lands in the cycle the pin 0 event is set
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        wr(OFF_EVT, 32'hFFFF_FFFF);
        rd(OFF_EVT, vw, vn);
        chk("R11 set wins wide", vw, 32'h8000_0000);
        chk("R11 set wins narrow", vn, 32'h8000_0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule